// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block is the digital control of a 64-element linear light-sensor array. A start input, sampled on a rising clock edge, drops a single token into a 64-stage shift register. On each later edge the token moves one pixel along, so that exactly one pixel at a time is selected onto the shared analog output. A one-hot select bus and a binary pixel index show which pixel is selected.

When the token leaves a pixel, that pixel's integrator gets a one-cycle reset strobe. The frame ends only when the token is shifted out of the last stage. Until then an output-enable stays high, and it stands for the output amplifier actually driving the pin. When the enable is low, the pin is treated as high-impedance.

The photodiodes, integrators and amplifier are not modelled. For test, a flat digital stand-in bus supplies one value per pixel. The value of the selected pixel appears on a modelled output port. A start request that arrives in the middle of a frame is dropped and reported with a one-cycle error pulse.

Top module: `lin_array_readout`

## Requirements
- R1: At most one bit of `pixSel` is ever high. Bit k (0-based) stands for pixel k+1.
- R2: Take a rising edge where `startIn` is high and no frame is running. After that edge, `pixSel` is 1 (pixel 1), `pixIdx` is 1 and `outEn` is 1.
- R3: Each later rising edge moves the token from pixel k to pixel k+1. `pixIdx` always gives the selected pixel number, from 1 to 64.
- R4: On the edge where the token leaves pixel k, bit k-1 of `intRst` goes high for exactly that one cycle. Otherwise `intRst` is zero.
- R5: Count the start edge as edge 1. The 65th edge clears the token and drives `outEn` low. That is also the edge that raises the reset strobe of pixel 64.
- R6: A start sampled on the 66th edge, the first edge after the frame has ended, opens a new frame at once. Consecutive frames are therefore 65 cycles apart.
- R7: A start sampled while `outEn` is high has no effect on the running frame. After that edge, `startErr` is high for one cycle. In every other cycle `startErr` is low.
- R8: While no frame is running, `outEn` is 0, `pixIdx` is 0, `pixSel` is 0 and `pixDataOut` is 0.
- R9: While pixel k+1 is selected, `pixDataOut` equals `pixDataIn[k*DATA_W +: DATA_W]`.
- R10: `rstN` low clears the token, the strobes and the error flag at once, without a clock. All outputs are then at their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Serial start request, sampled on each rising edge |
| pixDataIn | input | NUM_PIX*DATA_W | Digital stand-in values, one slice per pixel |
| pixSel | output | NUM_PIX | One-hot selected pixel (token register) |
| intRst | output | NUM_PIX | Per-pixel integrator reset strobes |
| outEn | output | 1 | Output driven (1) or high-impedance (0) |
| pixIdx | output | 7 | Selected pixel number, 0 when idle |
| pixDataOut | output | DATA_W | Stand-in value of the selected pixel, 0 when idle |
| startErr | output | 1 | One-cycle flag for a start dropped during a frame |

## Verification
Two cases are hard to reach: the boundary between frames and a start that lands on the last edge of a frame. In the second case the token sits on pixel 64, the request must be dropped, and the frame must still end on the next edge. The stimulus reaches both by holding `startIn` high for more than two whole frames. This produces an error pulse on every busy edge, including the one at pixel 64, and a clean restart exactly on the 66th edge. A separate single pulse placed at the 66th edge checks back-to-back frames without any error in between. An asynchronous reset asserted between edges in the middle of a frame checks that all outputs clear without waiting for a clock.

// File: rtl/lin_rd_pkg.sv
package lin_rd_pkg;
  // strobes from the control half to the token datapath
  typedef struct packed {
    logic load;   // drop a new token into stage 0
    logic drop;   // start seen while busy, discarded
  } rdStrobe_t;
endpackage

// File: rtl/lin_rd_ctrl.sv
module lin_rd_ctrl
  import lin_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      busy,
  output rdStrobe_t strb,
  output logic      startErr
);

  always_comb begin
    strb.load = startIn & ~busy;
    strb.drop = startIn & busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startErr <= 1'b0;
    else       startErr <= strb.drop;
  end

  AST_ERR_ON_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && busy) |=> startErr); // R7
  AST_ERR_ONLY_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(startIn && busy) |=> !startErr); // R7

endmodule

// File: rtl/lin_rd_path.sv
module lin_rd_path
  import lin_rd_pkg::*;
#(
  parameter int NUM_PIX = 64,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(NUM_PIX + 1)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  rdStrobe_t                 strb,
  input  logic [NUM_PIX*DATA_W-1:0] pixDataIn,
  output logic [NUM_PIX-1:0]        pixSel,
  output logic [NUM_PIX-1:0]        intRst,
  output logic                      outEn,
  output logic [IDX_W-1:0]          pixIdx,
  output logic [DATA_W-1:0]         pixDataOut,
  output logic                      busy
);

  localparam int LAST = NUM_PIX - 1;

  logic [NUM_PIX-1:0] token;

  // token shift register; a load only happens with an empty register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          token <= '0;
    else if (strb.load) token <= {{(NUM_PIX-1){1'b0}}, 1'b1};
    else                token <= token << 1;
  end

  // per-pixel reset strobe: set on the edge the token leaves that stage
  for (genvar k = 0; k < NUM_PIX; k++) begin : g_rstStrb
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) intRst[k] <= 1'b0;
      else       intRst[k] <= token[k];
    end
  end

  // one-hot to index and stand-in data mux
  always_comb begin
    pixIdx     = '0;
    pixDataOut = '0;
    for (int k = 0; k < NUM_PIX; k++) begin
      if (token[k]) begin
        pixIdx     = pixIdx | IDX_W'(k + 1);
        pixDataOut = pixDataOut | pixDataIn[k*DATA_W +: DATA_W];
      end
    end
  end

  assign pixSel = token;
  assign busy   = |token;
  assign outEn  = busy;

  AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixSel)); // R1
  AST_LOAD_PIXEL1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (pixIdx == IDX_W'(1) && outEn)); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !pixSel[LAST]) |=> (pixIdx == $past(pixIdx) + IDX_W'(1))); // R3
  AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outEn |=> (intRst == $past(pixSel))); // R4
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    pixSel[LAST] |=> (!outEn && intRst[LAST])); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (pixIdx == '0 && pixDataOut == '0)); // R8

endmodule

// File: rtl/lin_array_readout.sv
module lin_array_readout
  import lin_rd_pkg::*;
#(
  parameter int NUM_PIX = 64,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(NUM_PIX + 1)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startIn,
  input  logic [NUM_PIX*DATA_W-1:0] pixDataIn,
  output logic [NUM_PIX-1:0]        pixSel,
  output logic [NUM_PIX-1:0]        intRst,
  output logic                      outEn,
  output logic [IDX_W-1:0]          pixIdx,
  output logic [DATA_W-1:0]         pixDataOut,
  output logic                      startErr
);

  rdStrobe_t strb;
  logic      busy;

  lin_rd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .busy     (busy),
    .strb     (strb),
    .startErr (startErr)
  );

  lin_rd_path #(
    .NUM_PIX (NUM_PIX),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pixDataIn  (pixDataIn),
    .pixSel     (pixSel),
    .intRst     (intRst),
    .outEn      (outEn),
    .pixIdx     (pixIdx),
    .pixDataOut (pixDataOut),
    .busy       (busy)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (!outEn && pixSel == '0 && !startErr)); // R10

endmodule

// File: tb/lin_array_readout_tb.sv
module lin_array_readout_tb_top;
  localparam int NP = 64;
  localparam int DW = 8;

  typedef struct {int idx; int rIdx; bit err;} exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [NP*DW-1:0] pixDataIn;
  logic [NP-1:0] pixSel, intRst;
  logic outEn, startErr;
  logic [6:0] pixIdx;
  logic [DW-1:0] pixDataOut;

  int checkCnt = 0;
  int failCnt = 0;
  int mIdx = 0;
  exp_t q[$];

  always #2ns clk = ~clk;  // 250 MHz

  lin_array_readout dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .pixDataIn(pixDataIn),
    .pixSel(pixSel), .intRst(intRst), .outEn(outEn), .pixIdx(pixIdx),
    .pixDataOut(pixDataOut), .startErr(startErr)
  );

  function automatic logic [DW-1:0] pat(int k);
    return DW'(k * 29 + 3);
  endfunction

  function automatic logic [NP-1:0] oneAt(int n);
    return (n == 0) ? '0 : (NP'(1) << (n - 1));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: one clock, expected outcome pushed from the requirements
  task automatic cyc(bit s);
    exp_t e;
    @(negedge clk);
    startIn = s;
    e.err  = s && (mIdx != 0);           // R7
    e.rIdx = mIdx;                        // R4: pixel the token leaves
    if (mIdx == 0) mIdx = s ? 1 : 0;      // R2
    else mIdx = (mIdx == NP) ? 0 : mIdx + 1; // R3, R5
    e.idx = mIdx;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(pixSel == oneAt(e.idx), "R1/R3", "pixSel", pixSel, oneAt(e.idx));
        chk(pixIdx == 7'(e.idx), "R2/R3", "pixIdx", pixIdx, e.idx);
        chk(outEn == (e.idx != 0), "R5/R8", "outEn", outEn, e.idx != 0);
        chk(intRst == oneAt(e.rIdx), "R4", "intRst", intRst, oneAt(e.rIdx));
        chk(startErr == e.err, "R7", "startErr", startErr, e.err);
        chk(pixDataOut == ((e.idx == 0) ? '0 : pat(e.idx - 1)), "R9", "pixDataOut",
            pixDataOut, (e.idx == 0) ? 0 : pat(e.idx - 1));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    for (int k = 0; k < NP; k++) pixDataIn[k*DW +: DW] = pat(k);
    #1ns;
    // R10: reset state
    chk(!outEn && pixSel == '0 && intRst == '0 && pixIdx == 0 && !startErr,
        "R10", "reset outputs", {outEn, pixIdx}, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) cyc(0);                     // R8 idle
    // single frame, then idle
    cyc(1);
    repeat (70) cyc(0);
    // R6: restart exactly on the 66th edge
    cyc(1);
    repeat (64) cyc(0);
    cyc(1);
    repeat (67) cyc(0);
    // R7: start held high over two frames, incl. on pixel 64
    repeat (140) cyc(1);
    repeat (70) cyc(0);
    // R7: one stray start mid frame
    cyc(1);
    repeat (10) cyc(0);
    cyc(1);
    repeat (60) cyc(0);
    // R10: asynchronous reset mid frame
    cyc(1);
    repeat (20) cyc(0);
    @(negedge clk);
    #0.5ns;
    rstN = 1'b0;
    #0.5ns;
    chk(!outEn && pixSel == '0 && pixIdx == 0 && pixDataOut == '0, "R10",
        "async clear", {outEn, pixIdx}, 0);
    q.delete();
    mIdx = 0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) cyc(0);
    cyc(1);
    repeat (68) cyc(0);
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule